// File: doc/BRIEF.md
# Stochastic Bitstream Multiply/Add Unit

This block does arithmetic on fractions in [0,1] by turning each operand into a random bitstream. In each stream the chance of a 1 equals the operand's value. Two generators each own a linear-feedback shift register (LFSR) and compare its state against an unsigned operand, so each produces one stream bit per clock. A bitwise AND of the two streams gives a stream whose density is the product of the operands. A bitwise OR gives the saturating sum A+B−AB. Two counters tally the ones in these result streams over a chosen number of clocks, and each tally divided by the stream length is the result as a binary fraction.

A `start` pulse loads both LFSRs with their seeds, clears the tallies and starts a run. The run length is a power of two, chosen by its base-2 exponent. The tallies can be read at any time during the run, and they grow more accurate as more bits are counted. A one-cycle `done` pulse marks the end of the run, and the final tallies stay on the outputs until the next `start`. The two LFSRs use different feedback polynomials and different seeds, so their streams are decorrelated. Streams that were correlated would give wrong products and wrong sums.

Top module: `sc_arith_unit`

## Requirements
- R1: An operand of 0 yields a stream of all zeros. An operand of all ones (2^WIDTH−1) yields a stream of all ones. Any other operand v yields a 1 in each cycle in which (LFSR state − 1) < v, with the LFSR stepping through every nonzero state.
- R2: At the end of a run, `prod_cnt` equals the number of cycles in which both streams were 1.
- R3: At the end of a run, `sum_cnt` equals the number of cycles in which at least one stream was 1. `prod_cnt` never exceeds `sum_cnt`.
- R4: The run length is 2^`len_log`. Values of `len_log` below 3 are treated as 3, and values above 10 are treated as 10. A tally never exceeds the run length.
- R5: The two generators use different feedback polynomials and seeds. With both operands at 128 and a run length of 1024, `prod_cnt` lies in [160,352] and `sum_cnt` lies in [674,866]. These ranges are near a quarter and three quarters of the run length, not near one half.
- R6: Partial tallies are readable during a run. After k counting cycles each tally equals the number of result ones among the first k bits, and a tally grows by at most 1 per cycle.
- R7: `done` is high for exactly one cycle: the cycle right after the last bit of the run has been counted. Both tallies then hold their values until the next `start`.
- R8: `start` clears both tallies in the next cycle and reloads both LFSR seeds. A `start` during a run abandons that run and begins a new one.
- R9: After reset, both tallies are 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new run (one-cycle pulse) |
| op_a | input | WIDTH | Operand A, value op_a/(2^WIDTH−1) |
| op_b | input | WIDTH | Operand B, value op_b/(2^WIDTH−1) |
| len_log | input | LOG_W | Base-2 exponent of the run length, clamped to 3..10 |
| prod_cnt | output | CNT_W | Count of ones in the AND stream |
| sum_cnt | output | CNT_W | Count of ones in the OR stream |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench counts edges from the edge that samples `start`. Edge 0 clears the tallies, and edge k adds the k-th stream bit. The bench therefore reads a partial tally k edges later, and it expects `done` exactly 2^len_log edges later, with `done` low one edge before and one edge after. Operands of all zeros and all ones give tallies that are known exactly. An operand pair at 128 is checked against ranges that an uncorrelated product and sum must fall inside. All outputs are sampled on the falling edge, away from the edge at which the design updates them.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int SC_LOG_MIN = 3;

  // Clamp a requested length exponent into the supported window.
  function automatic int clamp_log(input int req, input int log_max);
    if (req < SC_LOG_MIN) return SC_LOG_MIN;
    if (req > log_max) return log_max;
    return req;
  endfunction

  typedef struct packed {
    logic a;
    logic b;
  } sc_bits_t;
endpackage

// File: rtl/sc_stream_gen.sv
module sc_stream_gen #(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 'hB8,
  parameter logic [WIDTH-1:0] SEED = 'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [WIDTH-1:0] level,
  output logic             bit_o
);
  logic [WIDTH-1:0] state;

  // Right-shifting Galois step; never reaches zero from a nonzero seed.
  function automatic logic [WIDTH-1:0] step(input logic [WIDTH-1:0] s);
    logic [WIDTH-1:0] sh;
    sh = s >> 1;
    return s[0] ? (sh ^ TAPS) : sh;
  endfunction

  // Offset by one so that state range 1..2^W-1 maps onto 0..2^W-2.
  function automatic logic emit(input logic [WIDTH-1:0] s, input logic [WIDTH-1:0] v);
    return (s - WIDTH'(1)) < v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= SEED;
    else if (reload) state <= SEED;
    else             state <= step(state);
  end

  assign bit_o = emit(state, level);
endmodule

// File: rtl/sc_ones_counter.sv
module sc_ones_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic             bit_in,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clear)            count <= '0;
    else if (enable && bit_in) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/sc_arith_unit.sv
module sc_arith_unit #(
  parameter int               WIDTH   = 8,
  parameter int               LOG_MAX = 10,
  parameter int               LOG_W   = 4,
  parameter int               CNT_W   = LOG_MAX + 1,
  parameter logic [WIDTH-1:0] TAPS_A  = 'hB8,
  parameter logic [WIDTH-1:0] TAPS_B  = 'h8E,
  parameter logic [WIDTH-1:0] SEED_A  = 'h01,
  parameter logic [WIDTH-1:0] SEED_B  = 'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [LOG_W-1:0] len_log,
  output logic [CNT_W-1:0] prod_cnt,
  output logic [CNT_W-1:0] sum_cnt,
  output logic             done
);
  import sc_pkg::*;

  localparam int NSTR = 2;
  localparam logic [WIDTH-1:0] TAPS_SET [NSTR] = '{TAPS_A, TAPS_B};
  localparam logic [WIDTH-1:0] SEED_SET [NSTR] = '{SEED_A, SEED_B};

  logic [WIDTH-1:0] levels [NSTR];
  logic [NSTR-1:0]  raw_bits;
  sc_bits_t         pair;
  logic             prod_bit;
  logic             sum_bit;
  logic             run_active;
  logic             count_en;
  logic [CNT_W-1:0] run_len;
  logic [CNT_W-1:0] remain;
  int               eff_log;

  assign levels[0] = op_a;
  assign levels[1] = op_b;

  for (genvar g = 0; g < NSTR; g++) begin : g_src
    sc_stream_gen #(.WIDTH(WIDTH), .TAPS(TAPS_SET[g]), .SEED(SEED_SET[g])) u_gen (
      .clk(clk), .rst_n(rst_n), .reload(start),
      .level(levels[g]), .bit_o(raw_bits[g])
    );
  end

  assign pair     = '{a: raw_bits[0], b: raw_bits[1]};
  assign prod_bit = pair.a & pair.b;
  assign sum_bit  = pair.a | pair.b;

  always_comb begin
    eff_log = clamp_log(int'(len_log), LOG_MAX);
    run_len = '0;
    run_len[eff_log] = 1'b1;
  end

  assign count_en = run_active && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_active <= 1'b0;
      remain     <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run_active <= 1'b1;
        remain     <= run_len;
      end else if (run_active) begin
        remain <= remain - CNT_W'(1);
        if (remain == CNT_W'(1)) begin
          run_active <= 1'b0;
          done       <= 1'b1;
        end
      end
    end
  end

  sc_ones_counter #(.CNT_W(CNT_W)) u_prod (
    .clk(clk), .rst_n(rst_n), .clear(start), .enable(count_en),
    .bit_in(prod_bit), .count(prod_cnt)
  );

  sc_ones_counter #(.CNT_W(CNT_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .clear(start), .enable(count_en),
    .bit_in(sum_bit), .count(sum_cnt)
  );
endmodule

// File: rtl/sc_arith_unit_chk.sv
module sc_arith_unit_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             run_active,
  input logic [CNT_W-1:0] prod_cnt,
  input logic [CNT_W-1:0] sum_cnt,
  input logic             done
);
  a_r3_prod_not_above_sum: assert property (@(posedge clk) disable iff (!rst_n)
    prod_cnt <= sum_cnt);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !run_active);

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (prod_cnt == '0) && (sum_cnt == '0));

  a_r6_step_le_one: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (sum_cnt <= $past(sum_cnt) + CNT_W'(1)) && (sum_cnt >= $past(sum_cnt)));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_active && !start) |=> $stable(prod_cnt) && $stable(sum_cnt));
endmodule

bind sc_arith_unit sc_arith_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .run_active(run_active),
  .prod_cnt(prod_cnt), .sum_cnt(sum_cnt), .done(done)
);

// File: tb/sc_arith_unit_test.sv
`timescale 1ns/1ps
module sc_arith_unit_test;
  localparam int WIDTH = 8;
  localparam int CNT_W = 11;
  localparam int LOG_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] op_a = '0;
  logic [WIDTH-1:0] op_b = '0;
  logic [LOG_W-1:0] len_log = 4'd3;
  logic [CNT_W-1:0] prod_cnt;
  logic [CNT_W-1:0] sum_cnt;
  logic             done;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sc_arith_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .len_log(len_log), .prod_cnt(prod_cnt), .sum_cnt(sum_cnt), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_in(input string req, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=[%0d,%0d]", req, act, lo, hi);
    end
  endtask

  // Issue start; returns at the falling edge right after the sampling edge.
  task automatic kick(input int a, input int b, input int lg);
    @(negedge clk);
    op_a = WIDTH'(a); op_b = WIDTH'(b); len_log = LOG_W'(lg); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Full run with expected final tallies, done timing and hold afterwards.
  task automatic run_exact(input string req, input int a, input int b, input int lg,
                           input int len, input int ep, input int es);
    kick(a, b, lg);
    check({req, " cleared"}, int'(sum_cnt), 0);
    repeat (len - 1) @(negedge clk);
    check("R7 done low before end", int'(done), 0);
    @(negedge clk);
    check("R7 done at end", int'(done), 1);
    check({req, " product"}, int'(prod_cnt), ep);
    check({req, " sum"}, int'(sum_cnt), es);
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check("R7 tallies hold", int'(sum_cnt), es);
  endtask

  task automatic t_reset;
    check("R9 prod reset", int'(prod_cnt), 0);
    check("R9 sum reset", int'(sum_cnt), 0);
    check("R9 done reset", int'(done), 0);
  endtask

  task automatic t_extremes;
    run_exact("R1 R2 R3 zero-zero", 0, 0, 3, 8, 0, 0);
    run_exact("R1 R2 R3 full-full", 255, 255, 4, 16, 16, 16);
    run_exact("R1 R2 R3 zero-full", 0, 255, 5, 32, 0, 32);
    run_exact("R1 R2 R3 full-zero", 255, 0, 3, 8, 0, 8);
  endtask

  task automatic t_clamp;
    run_exact("R4 low clamp", 255, 255, 0, 8, 8, 8);
    run_exact("R4 high clamp", 255, 255, 15, 1024, 1024, 1024);
  endtask

  task automatic t_partial;
    kick(255, 255, 6);
    repeat (20) @(negedge clk);
    check("R6 partial product", int'(prod_cnt), 20);
    check("R6 partial sum", int'(sum_cnt), 20);
    check("R6 no done mid-run", int'(done), 0);
    repeat (44) @(negedge clk);
    check("R6 final after partial", int'(prod_cnt), 64);
  endtask

  task automatic t_restart;
    kick(255, 0, 10);
    repeat (5) @(negedge clk);
    check("R8 pre-restart sum", int'(sum_cnt), 5);
    kick(255, 255, 3);
    check("R8 restart clears", int'(prod_cnt), 0);
    repeat (8) @(negedge clk);
    check("R8 restarted run done", int'(done), 1);
    check("R8 restarted run count", int'(prod_cnt), 8);
  endtask

  task automatic t_halves;
    kick(128, 128, 10);
    repeat (1024) @(negedge clk);
    check("R5 done", int'(done), 1);
    check_in("R5 uncorrelated product", int'(prod_cnt), 160, 352);
    check_in("R5 uncorrelated sum", int'(sum_cnt), 674, 866);
    check_in("R4 sum within length", int'(sum_cnt), 0, 1024);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    #6 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_extremes();
    t_clamp();
    t_partial();
    t_restart();
    t_halves();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule